// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Detection

This block recovers characters from an asynchronous serial line. It waits for a falling edge on the line, confirms the start bit half a bit time later, then shifts in 7, 8 or 9 data bits, least significant bit first. After the data bits it samples one parity bit and one stop bit. Bit timing comes from an enable pulse at sixteen times the bit rate, which the surrounding logic supplies.

Each finished character is loaded into a receive buffer and marks the buffer as full. Reading the buffer clears that mark. The receiver checks parity, framing and overrun on every character, and each kind of failure has its own sticky flag that only a software clear strobe resets. A receive interrupt and an error interrupt each pulse for one cycle per character, and only when enabled. The error interrupt fires again on the next character for as long as any flag stays set.

Top module: `uart_rx_err`

## Requirements
- R1: While `rx_en` is low, the receiver stays idle. A frame on `rx` then loads nothing and raises no interrupt.
- R2: The line passes through a two-flop synchronizer. A start bit is confirmed on the 8th sample tick after the falling edge is seen. If the line is high at that point, the event is dropped as a glitch.
- R3: Data bits are taken least significant bit first, one every 16 sample ticks. `len_sel` sets the count: 0 = 7 bits, 1 = 8 bits, 2 or 3 = 9 bits. One parity bit and one stop bit follow the data bits.
- R4: Parity is counted over the configured data bits only. With `par_odd`=0, the data ones plus the parity bit must total an even number. With `par_odd`=1, the total must be odd.
- R5: A parity failure sets `par_err`.
- R6: A stop bit sampled as 0 sets `frm_err`. The receiver then waits for the line to return high before it looks for a new start bit.
- R7: When a character completes, `rx_data` is loaded and `buf_full` is set. If `rx_ie` is high, `rx_irq` pulses for one cycle. A one-cycle `rd_buf` clears `buf_full`.
- R8: `par_err`, `ovr_err` and `frm_err` stay set until their own clear strobe (`clr_par`, `clr_ovr`, `clr_frm`) is pulsed. If a flag is set and cleared in the same cycle, the set wins.
- R9: When a character completes and `err_ie` is high, `err_irq` pulses for one cycle if that character failed a check or if any flag is still set.
- R10: A character that completes while `buf_full` is set, with no read in the same cycle, sets `ovr_err`. In that case `rx_data` keeps the older character.
- R11: The unused upper bits of `rx_data` read as zero: bits 8:7 for 7-bit characters, and bit 8 for 8-bit characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Enable pulse at 16x the bit rate |
| rx | input | 1 | Serial line, idles high |
| rx_en | input | 1 | Receive enable |
| len_sel | input | 2 | Character length: 0=7, 1=8, 2/3=9 bits |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Error interrupt enable |
| rd_buf | input | 1 | Buffer read strobe |
| clr_par | input | 1 | Clear strobe for the parity flag |
| clr_ovr | input | 1 | Clear strobe for the overrun flag |
| clr_frm | input | 1 | Clear strobe for the framing flag |
| rx_data | output | 9 | Receive buffer |
| buf_full | output | 1 | Buffer holds an unread character |
| par_err | output | 1 | Sticky parity error flag |
| ovr_err | output | 1 | Sticky overrun flag |
| frm_err | output | 1 | Sticky framing error flag |
| rx_irq | output | 1 | One-cycle receive interrupt |
| err_irq | output | 1 | One-cycle error interrupt |

## Verification
Each fault in the frame state shows up at the ports within one character.

| Internal fault | What appears at the ports |
|---|---|
| Wrong bit counter | A shifted or truncated value in `rx_data` right after the stop bit |
| Wrong mid-bit counter | A glitch accepted as a character, or a good character lost |
| Bad flag or overrun logic | A missing or extra `err_irq` on the very character that should trigger it, and a buffer that changes when it should hold |

Each directed scenario therefore reads the buffer, the flags and the interrupt pulse counts a few cycles after the stop bit ends.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int MAX_BITS = 9;
  localparam int OVS      = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BREAK
  } rx_state_e;

  function automatic logic [3:0] char_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd7;
      2'd1:    return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  function automatic logic [MAX_BITS-1:0] len_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    return 9'h07F;
      2'd1:    return 9'h0FF;
      default: return 9'h1FF;
    endcase
  endfunction

  // shift register fills from the top; move the character down to bit 0
  function automatic logic [MAX_BITS-1:0] align_char(input logic [MAX_BITS-1:0] sh,
                                                     input logic [1:0] sel);
    case (sel)
      2'd0:    return {2'b00, sh[8:2]};
      2'd1:    return {1'b0, sh[8:1]};
      default: return sh;
    endcase
  endfunction

  function automatic logic parity_good(input logic [MAX_BITS-1:0] d,
                                       input logic [1:0] sel,
                                       input logic odd, input logic pbit);
    return ((^(d & len_mask(sel))) ^ pbit) == odd;
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS_N = OVS,
  parameter int BITS  = MAX_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            en,
  input  logic            rx_s,
  input  logic [1:0]      len_sel,
  output logic            done,
  output logic [BITS-1:0] char_o,
  output logic            pbit_o,
  output logic            stop_o
);
  localparam int CW = $clog2(OVS_N);
  localparam logic [CW-1:0] HALF = CW'(OVS_N / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS_N - 1);

  rx_state_e       state;
  logic [CW-1:0]   cnt;
  logic [3:0]      bitn;
  logic [BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      shreg  <= '0;
      pbit_o <= 1'b0;
      stop_o <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (tick) begin
        case (state)
          ST_IDLE: if (!rx_s) begin
            state <= ST_START;
            cnt   <= '0;
          end
          ST_START: begin
            if (cnt == HALF) begin
              cnt  <= '0;
              bitn <= '0;
              state <= rx_s ? ST_IDLE : ST_DATA;
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            if (cnt == LAST) begin
              cnt   <= '0;
              shreg <= {rx_s, shreg[BITS-1:1]};
              if (bitn == char_len(len_sel) - 4'd1) state <= ST_PAR;
              else bitn <= bitn + 4'd1;
            end else cnt <= cnt + 1'b1;
          end
          ST_PAR: begin
            if (cnt == LAST) begin
              cnt    <= '0;
              pbit_o <= rx_s;
              state  <= ST_STOP;
            end else cnt <= cnt + 1'b1;
          end
          ST_STOP: begin
            if (cnt == LAST) begin
              cnt    <= '0;
              stop_o <= rx_s;
              done   <= 1'b1;
              state  <= rx_s ? ST_IDLE : ST_BREAK;
            end else cnt <= cnt + 1'b1;
          end
          ST_BREAK: if (rx_s) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign char_o = align_char(shreg, len_sel);

  p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == ST_IDLE && !done));
  p_glitch_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && state == ST_START && cnt == HALF && rx_s) |=> state == ST_IDLE);
  p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && len_sel == 2'd0) |-> char_o[8:7] == 2'b00);
  p_wait_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BREAK && !rx_s) |=> (state == ST_BREAK || !en));
endmodule

// File: rtl/rx_status.sv
module rx_status #(
  parameter int BITS = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done,
  input  logic [BITS-1:0] char_i,
  input  logic            par_fail,
  input  logic            frm_fail,
  input  logic            rd_buf,
  input  logic            clr_par,
  input  logic            clr_ovr,
  input  logic            clr_frm,
  input  logic            rx_ie,
  input  logic            err_ie,
  output logic [BITS-1:0] data_q,
  output logic            full_q,
  output logic            par_q,
  output logic            ovr_q,
  output logic            frm_q,
  output logic            rx_irq,
  output logic            err_irq
);
  logic ovr_now, any_new, any_old;

  assign ovr_now = done && full_q && !rd_buf;
  assign any_new = par_fail || frm_fail || ovr_now;
  assign any_old = par_q || ovr_q || frm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      full_q  <= 1'b0;
      par_q   <= 1'b0;
      ovr_q   <= 1'b0;
      frm_q   <= 1'b0;
      rx_irq  <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      rx_irq  <= done && rx_ie;
      err_irq <= done && err_ie && (any_new || any_old);
      if (done && !ovr_now) begin
        data_q <= char_i;
        full_q <= 1'b1;
      end else if (rd_buf) begin
        full_q <= 1'b0;
      end
      par_q <= (done && par_fail) || (par_q && !clr_par);
      frm_q <= (done && frm_fail) || (frm_q && !clr_frm);
      ovr_q <= ovr_now || (ovr_q && !clr_ovr);
    end
  end

  p_keep_old_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && full_q && !rd_buf) |=> ($stable(data_q) && ovr_q));
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && !done) |=> !full_q);
  p_sticky_par_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (par_q && !clr_par) |=> par_q);
  p_sticky_frm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_q && !clr_frm) |=> frm_q);
  p_reraise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_ie && par_q) |=> err_irq);
endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       rx,
  input  logic       rx_en,
  input  logic [1:0] len_sel,
  input  logic       par_odd,
  input  logic       rx_ie,
  input  logic       err_ie,
  input  logic       rd_buf,
  input  logic       clr_par,
  input  logic       clr_ovr,
  input  logic       clr_frm,
  output logic [8:0] rx_data,
  output logic       buf_full,
  output logic       par_err,
  output logic       ovr_err,
  output logic       frm_err,
  output logic       rx_irq,
  output logic       err_irq
);
  logic                rx_s;
  logic                char_done;
  logic [MAX_BITS-1:0] char_w;
  logic                pbit_w, stop_w;
  logic                par_fail, frm_fail;

  rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx), .q(rx_s)
  );

  rx_frame #(.OVS_N(OVS), .BITS(MAX_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .en(rx_en), .rx_s(rx_s),
    .len_sel(len_sel), .done(char_done), .char_o(char_w),
    .pbit_o(pbit_w), .stop_o(stop_w)
  );

  assign par_fail = !parity_good(char_w, len_sel, par_odd, pbit_w);
  assign frm_fail = !stop_w;

  rx_status #(.BITS(MAX_BITS)) u_status (
    .clk(clk), .rst_n(rst_n), .done(char_done), .char_i(char_w),
    .par_fail(par_fail), .frm_fail(frm_fail), .rd_buf(rd_buf),
    .clr_par(clr_par), .clr_ovr(clr_ovr), .clr_frm(clr_frm),
    .rx_ie(rx_ie), .err_ie(err_ie), .data_q(rx_data), .full_q(buf_full),
    .par_q(par_err), .ovr_q(ovr_err), .frm_q(frm_err),
    .rx_irq(rx_irq), .err_irq(err_irq)
  );
endmodule

// File: tb/uart_rx_err_tb.sv
module uart_rx_err_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sample_tick = 1'b1, rx = 1'b1, rx_en = 1'b1;
  logic [1:0] len_sel = 2'd1;
  logic par_odd = 1'b0, rx_ie = 1'b1, err_ie = 1'b1;
  logic rd_buf = 1'b0, clr_par = 1'b0, clr_ovr = 1'b0, clr_frm = 1'b0;
  logic [8:0] rx_data;
  logic buf_full, par_err, ovr_err, frm_err, rx_irq, err_irq;
  int checks = 0, errors = 0, n_rx = 0, n_err = 0;
  bit done_flag = 0;

  uart_rx_err u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    if (rx_irq)  n_rx++;
    if (err_irq) n_err++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic ref_par(input logic [8:0] d, input int len, input logic odd);
    int ones = 0;
    for (int i = 0; i < len; i++) ones += d[i];
    return odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
  endfunction

  task automatic hold(input logic v);
    rx = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int len, input logic flip, input logic stopv);
    @(negedge clk);
    hold(1'b0);
    for (int i = 0; i < len; i++) hold(d[i]);
    hold(ref_par(d, len, par_odd) ^ flip);
    hold(stopv);
    rx = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic pulse_rd();
    rd_buf = 1'b1; @(negedge clk); rd_buf = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    check("R7 reset buf_full", buf_full, 0);
    check("R8 reset flags", {par_err, ovr_err, frm_err}, 0);
  endtask

  task automatic t_eight();
    int r0 = n_rx, e0 = n_err;
    len_sel = 2'd1; par_odd = 1'b0;
    send(9'h0A5, 8, 0, 1);
    check("R3 8-bit data", rx_data, 9'h0A5);
    check("R7 buf_full", buf_full, 1);
    check("R7 rx_irq count", n_rx - r0, 1);
    check("R4 no err irq", n_err - e0, 0);
    pulse_rd();
    check("R7 read clears", buf_full, 0);
  endtask

  task automatic t_seven();
    len_sel = 2'd0; par_odd = 1'b1;
    send(9'h1D5, 7, 0, 1);
    check("R11 7-bit upper zero", rx_data, 9'h055);
    check("R4 odd parity ok", par_err, 0);
    pulse_rd();
  endtask

  task automatic t_nine();
    len_sel = 2'd2; par_odd = 1'b1;
    send(9'h1C3, 9, 0, 1);
    check("R3 9-bit data", rx_data, 9'h1C3);
    check("R4 9-bit parity ok", par_err, 0);
    pulse_rd();
  endtask

  task automatic t_parity();
    int e0 = n_err;
    len_sel = 2'd1; par_odd = 1'b0;
    send(9'h03C, 8, 1, 1);
    check("R5 par_err set", par_err, 1);
    check("R9 err irq", n_err - e0, 1);
    pulse_rd();
    send(9'h011, 8, 0, 1);
    check("R8 par_err sticky", par_err, 1);
    check("R9 re-raise", n_err - e0, 2);
    pulse_rd();
    @(negedge clk); clr_par = 1'b1; @(negedge clk); clr_par = 1'b0; @(negedge clk);
    check("R8 clr_par", par_err, 0);
  endtask

  task automatic t_frame();
    len_sel = 2'd1; par_odd = 1'b0;
    send(9'h066, 8, 0, 0);
    check("R6 frm_err", frm_err, 1);
    pulse_rd();
    clr_frm = 1'b1; @(negedge clk); clr_frm = 1'b0; @(negedge clk);
    send(9'h099, 8, 0, 1);
    check("R6 recovers after break", rx_data, 9'h099);
    check("R6 flag cleared", frm_err, 0);
    pulse_rd();
  endtask

  task automatic t_overrun();
    send(9'h012, 8, 0, 1);
    send(9'h034, 8, 0, 1);
    check("R10 ovr_err", ovr_err, 1);
    check("R10 old data kept", rx_data, 9'h012);
    pulse_rd();
    clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0; @(negedge clk);
    check("R8 clr_ovr", ovr_err, 0);
  endtask

  task automatic t_glitch();
    int r0 = n_rx;
    @(negedge clk); rx = 1'b0;
    repeat (3) @(negedge clk);
    rx = 1'b1;
    repeat (BIT_CLKS * 12) @(negedge clk);
    check("R2 glitch ignored", n_rx - r0, 0);
    check("R2 buffer empty", buf_full, 0);
  endtask

  task automatic t_disable();
    int r0 = n_rx;
    rx_en = 1'b0;
    send(9'h0F0, 8, 0, 1);
    check("R1 no irq when disabled", n_rx - r0, 0);
    check("R1 no load when disabled", buf_full, 0);
    rx_en = 1'b1;
  endtask

  task automatic t_irq_off();
    int r0 = n_rx;
    rx_ie = 1'b0;
    send(9'h05A, 8, 0, 1);
    check("R7 rx_irq masked", n_rx - r0, 0);
    check("R7 loaded while masked", rx_data, 9'h05A);
    rx_ie = 1'b1;
    pulse_rd();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_eight();
    t_seven();
    t_nine();
    t_parity();
    t_frame();
    t_overrun();
    t_glitch();
    t_disable();
    t_irq_off();
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule